// File: doc/BRIEF.md
# Modem Handshake Control and Status

This block is the modem handshake section of a 16550-style serial port. A small control register, written through a simple strobe-and-data port, drives two active-low handshake outputs: terminal-ready and request-to-send. A status word, read through a strobe, has two halves. Its upper nibble gives the asserted level of four active-low modem inputs: clear-to-send, data-set-ready, ring-indicator and carrier-detect. Its lower nibble holds one sticky change flag for each of those inputs. A flag is set when its pin returns from low to high, and the read clears the flags.

The four modem pins pass through a two-stage synchronizer before any edge is detected. A loop-mode input cuts the block off from the outside world. Both handshake outputs are held inactive. The status inputs are fed from control register bits instead of the pins.

A two-state machine produces the modem-status interrupt. In state MSI_QUIET the interrupt is low. The transition QUIET_TO_RAISED is taken when the enable is on and at least one change flag is set. In state MSI_RAISED the interrupt is high. The transition RAISED_TO_QUIET is taken when the enable goes off or all flags are clear. Clear-to-send only feeds the status word and has no path into any transmitter.

Top module: `modem_hs_ctrl`

## Requirements
- R1: After reset, `dtr_n` and `rts_n` are high, the four change flags (status bits 3:0) are zero and `irq` is low.
- R2: With `loop_en` low, control bit 0 drives `dtr_n` and control bit 1 drives `rts_n`. Each output is the inverse of its bit and takes the new value right after the edge that captures `ctl_wr`.
- R3: While `loop_en` is high, both `dtr_n` and `rts_n` are high, whatever the control register holds.
- R4: Status bits 4, 5, 6 and 7 give the inverted level of `cts_n`, `dsr_n`, `ri_n` and `dcd_n` in that order. A pin change shows there after two clock edges.
- R5: Status bits 0, 1, 2 and 3 are the change flags of `cts_n`, `dsr_n`, `ri_n` and `dcd_n` in that order. A flag is set three edges after its pin goes from low to high. A high-to-low change sets no flag.
- R6: The edge that captures `sts_rd` clears status bits 3:0 and leaves bits 7:4 as they are.
- R7: If a qualifying low-to-high change reaches the edge detector in the same cycle as a read, its flag is still set after that edge.
- R8: With `msi_en` high, `irq` rises one edge after any change flag is set. It stays high while any flag is set.
- R9: `irq` falls one edge after the flags are cleared or `msi_en` goes low. With `msi_en` low, `irq` stays low.
- R10: In loop mode the status inputs come from control bits: bit 1 feeds clear-to-send, bit 0 feeds data-set-ready, bit 2 feeds ring-indicator and bit 3 feeds carrier-detect. The pins are ignored, and the new levels show right after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | CTL_W | Control register write data |
| sts_rd | input | 1 | Status read strobe; clears change flags |
| sts_rdata | output | 8 | Status word: levels in 7:4, change flags in 3:0 |
| msi_en | input | 1 | Modem-status interrupt enable |
| loop_en | input | 1 | Loop mode |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring-indicator pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| dtr_n | output | 1 | Terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| irq | output | 1 | Modem-status interrupt |

## Verification
Each result has a fixed latency:
- A pin change shows in the level bits two edges after it is driven and in its change flag three edges after it is driven.
- `irq` follows a flag by one more edge.
- A control write changes the outputs right after the capturing edge, and in loop mode it changes the looped levels at that same edge.
- A read clears the flags at its own edge, and `irq` falls one edge later.

The bench drives inputs just after a rising edge and counts whole edges before it samples. It also checks the cycle one edge before each result is due, so a shorter latency is caught as well as a missing result.

// File: rtl/modem_hs_pkg.sv
package modem_hs_pkg;
    localparam int NUM_LINES = 4;
    // line order inside vectors; the status word layout depends on it
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;
    // control register bit positions
    localparam int CB_DTR = 0;
    localparam int CB_RTS = 1;
    localparam int CB_AUX_RI  = 2;
    localparam int CB_AUX_DCD = 3;

    typedef enum logic {
        MSI_QUIET  = 1'b0,
        MSI_RAISED = 1'b1
    } msi_state_t;
endpackage

// File: rtl/modem_sync_bank.sv
module modem_sync_bank #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_n,
    output logic [WIDTH-1:0] q_n
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_line
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '1;
                else        sh <= {sh[STAGES-2:0], d_n[i]};
            end
            assign q_n[i] = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/modem_change_det.sv
module modem_change_det #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_n,
    input  logic             rd,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] flags
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] flags_d;

    // active-low line returning high: previous low, present high
    assign rise = ~prev_q & level_n;

    always_comb begin
        flags_d = flags;
        if (rd) flags_d = '0;
        flags_d = flags_d | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
            flags  <= '0;
        end else begin
            prev_q <= level_n;
            flags  <= flags_d;
        end
    end
endmodule

// File: rtl/modem_irq_fsm.sv
module modem_irq_fsm
    import modem_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pending,
    output logic irq
);
    msi_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MSI_QUIET:  if (en && pending)   state_d = MSI_RAISED;
            MSI_RAISED: if (!en || !pending) state_d = MSI_QUIET;
            default:                         state_d = MSI_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MSI_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = 1'b0;
        unique case (state_q)
            MSI_QUIET:  irq = 1'b0;
            MSI_RAISED: irq = 1'b1;
            default:    irq = 1'b0;
        endcase
    end
endmodule

// File: rtl/modem_hs_ctrl.sv
module modem_hs_ctrl
    import modem_hs_pkg::*;
#(
    parameter int CTL_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_wr,
    input  logic [CTL_W-1:0]       ctl_wdata,
    input  logic                   sts_rd,
    output logic [2*NUM_LINES-1:0] sts_rdata,
    input  logic                   msi_en,
    input  logic                   loop_en,
    input  logic                   cts_n,
    input  logic                   dsr_n,
    input  logic                   ri_n,
    input  logic                   dcd_n,
    output logic                   dtr_n,
    output logic                   rts_n,
    output logic                   irq
);
    localparam int STS_W = 2 * NUM_LINES;

    logic [CTL_W-1:0]     ctl_q;
    logic [NUM_LINES-1:0] pin_n, sync_n, loop_n, level_n;
    logic [NUM_LINES-1:0] line_rise, line_flags;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= ctl_wdata;
    end

    assign dtr_n = loop_en | ~ctl_q[CB_DTR];
    assign rts_n = loop_en | ~ctl_q[CB_RTS];

    always_comb begin
        pin_n[LN_CTS] = cts_n;
        pin_n[LN_DSR] = dsr_n;
        pin_n[LN_RI]  = ri_n;
        pin_n[LN_DCD] = dcd_n;
        loop_n[LN_CTS] = ~ctl_q[CB_RTS];
        loop_n[LN_DSR] = ~ctl_q[CB_DTR];
        loop_n[LN_RI]  = ~ctl_q[CB_AUX_RI];
        loop_n[LN_DCD] = ~ctl_q[CB_AUX_DCD];
    end

    modem_sync_bank #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_n   (pin_n),
        .q_n   (sync_n)
    );

    assign level_n = loop_en ? loop_n : sync_n;

    modem_change_det #(.WIDTH(NUM_LINES)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_n (level_n),
        .rd      (sts_rd),
        .rise    (line_rise),
        .flags   (line_flags)
    );

    modem_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (msi_en),
        .pending (|line_flags),
        .irq     (irq)
    );

    assign sts_rdata[STS_W-1:NUM_LINES] = ~level_n;
    assign sts_rdata[NUM_LINES-1:0]     = line_flags;
endmodule

// File: rtl/modem_hs_ctrl_chk.sv
module modem_hs_ctrl_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ctl_wr,
    input logic         sts_rd,
    input logic         msi_en,
    input logic         loop_en,
    input logic         dtr_n,
    input logic         rts_n,
    input logic         irq,
    input logic [W-1:0] flags,
    input logic [W-1:0] rise
);
    // R3
    a_r3_loop_outputs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (dtr_n && rts_n));

    // R2
    a_r2_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> (!$stable(loop_en) || $stable({dtr_n, rts_n})));

    // R5
    a_r5_flag_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~($past(flags) | $past(rise))) == '0));

    // R6, R7
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rd |=> ((flags & ~$past(rise)) == '0));

    // R8
    a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(msi_en && (|flags)));

    // R9
    a_r9_irq_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_en |=> !irq);
endmodule

bind modem_hs_ctrl modem_hs_ctrl_chk #(.W(modem_hs_pkg::NUM_LINES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_wr  (ctl_wr),
    .sts_rd  (sts_rd),
    .msi_en  (msi_en),
    .loop_en (loop_en),
    .dtr_n   (dtr_n),
    .rts_n   (rts_n),
    .irq     (irq),
    .flags   (line_flags),
    .rise    (line_rise)
);

// File: tb/modem_hs_ctrl_tb.sv
module modem_hs_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [3:0] ctl_wdata = '0;
    logic       sts_rd = 1'b0;
    logic [7:0] sts_rdata;
    logic       msi_en = 1'b0;
    logic       loop_en = 1'b0;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic       dtr_n, rts_n, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    modem_hs_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .sts_rd(sts_rd), .sts_rdata(sts_rdata), .msi_en(msi_en),
        .loop_en(loop_en), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
        .dcd_n(dcd_n), .dtr_n(dtr_n), .rts_n(rts_n), .irq(irq)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_pins(input logic [3:0] p);   // {dcd, ri, dsr, cts}
        {dcd_n, ri_n, dsr_n, cts_n} = p;
    endtask

    task automatic write_ctl(input logic [3:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        step(1);
        ctl_wr = 1'b0;
    endtask

    task automatic do_read(output logic [7:0] v);
        sts_rd = 1'b1;
        v = sts_rdata;
        step(1);
        sts_rd = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 dtr_n/rts_n", {6'd0, dtr_n, rts_n}, 8'h03);
        chk("R1 flags", {4'd0, sts_rdata[3:0]}, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_ctl_outputs;
        write_ctl(4'b0001);
        chk("R2 dtr only", {6'd0, dtr_n, rts_n}, 8'h01);
        write_ctl(4'b0010);
        chk("R2 rts only", {6'd0, dtr_n, rts_n}, 8'h02);
        write_ctl(4'b0011);
        chk("R2 both", {6'd0, dtr_n, rts_n}, 8'h00);
    endtask

    task automatic t_levels;
        set_pins(4'b1110);
        step(1);
        chk("R4 cts not yet", {4'd0, sts_rdata[7:4]}, 8'h00);
        step(1);
        chk("R4 cts level bit4", {4'd0, sts_rdata[7:4]}, 8'h01);
        set_pins(4'b1100); step(2);
        chk("R4 dsr bit5", {4'd0, sts_rdata[7:4]}, 8'h03);
        set_pins(4'b1000); step(2);
        chk("R4 ri bit6", {4'd0, sts_rdata[7:4]}, 8'h07);
        set_pins(4'b0000); step(3);
        chk("R4 dcd bit7", {4'd0, sts_rdata[7:4]}, 8'h0F);
        chk("R5 falling sets none", {4'd0, sts_rdata[3:0]}, 8'h00);
    endtask

    task automatic t_rise_and_read;
        logic [7:0] v;
        set_pins(4'b1111);
        step(2);
        chk("R5 flags not yet", {4'd0, sts_rdata[3:0]}, 8'h00);
        step(1);
        chk("R5 all flags", {4'd0, sts_rdata[3:0]}, 8'h0F);
        chk("R9 irq off when disabled", {7'd0, irq}, 8'h00);
        do_read(v);
        chk("R6 read value", v, 8'h0F);
        chk("R6 flags cleared", sts_rdata, 8'h00);
    endtask

    task automatic t_irq;
        logic [7:0] v;
        msi_en = 1'b1;
        set_pins(4'b1110); step(3);
        set_pins(4'b1111); step(3);
        chk("R8 flag set irq not yet", {7'd0, irq}, 8'h00);
        step(1);
        chk("R8 irq raised", {7'd0, irq}, 8'h01);
        step(3);
        chk("R8 irq held", {7'd0, irq}, 8'h01);
        do_read(v);
        chk("R9 irq one edge after clear", {7'd0, irq}, 8'h01);
        step(1);
        chk("R9 irq dropped", {7'd0, irq}, 8'h00);
        set_pins(4'b0111); step(3);
        set_pins(4'b1111); step(4);
        chk("R8 irq from dcd", {7'd0, irq}, 8'h01);
        msi_en = 1'b0;
        step(1);
        chk("R9 irq off on disable", {7'd0, irq}, 8'h00);
        chk("R9 flag kept", {4'd0, sts_rdata[3:0]}, 8'h08);
        do_read(v);
    endtask

    task automatic t_coincide;
        logic [7:0] v;
        set_pins(4'b1101); step(3);
        set_pins(4'b1111); step(3);
        set_pins(4'b1101); step(3);
        chk("R7 flag set before", {4'd0, sts_rdata[3:0]}, 8'h02);
        set_pins(4'b1111); step(2);
        do_read(v);
        chk("R7 flag survives read", {4'd0, sts_rdata[3:0]}, 8'h02);
        do_read(v);
        chk("R6 second read clears", {4'd0, sts_rdata[3:0]}, 8'h00);
    endtask

    task automatic t_loop;
        logic [7:0] v;
        loop_en = 1'b1;
        step(1);
        chk("R3 outputs forced idle", {6'd0, dtr_n, rts_n}, 8'h03);
        do_read(v);
        write_ctl(4'b0010);
        chk("R10 rts->cts", {4'd0, sts_rdata[7:4]}, 8'h01);
        write_ctl(4'b0001);
        chk("R10 dtr->dsr", {4'd0, sts_rdata[7:4]}, 8'h02);
        write_ctl(4'b0100);
        chk("R10 bit2->ri", {4'd0, sts_rdata[7:4]}, 8'h04);
        write_ctl(4'b1000);
        chk("R10 bit3->dcd", {4'd0, sts_rdata[7:4]}, 8'h08);
        write_ctl(4'b1111);
        chk("R3 outputs idle with ctl set", {6'd0, dtr_n, rts_n}, 8'h03);
        do_read(v);
        set_pins(4'b0000); step(3);
        chk("R10 pins ignored", sts_rdata, 8'hF0);
        set_pins(4'b1111); step(3);
        write_ctl(4'b0000);
        chk("R10 levels drop at write edge", sts_rdata, 8'h00);
        step(1);
        chk("R10 looped rises flagged", sts_rdata, 8'h0F);
        do_read(v);
        loop_en = 1'b0;
        step(1);
        write_ctl(4'b0011);
        chk("R2 outputs back after loop", {6'd0, dtr_n, rts_n}, 8'h00);
        chk("R5 no flags from loop exit", sts_rdata, 8'h00);
    endtask

    initial begin
        step(3);
        t_reset;
        rst_n = 1'b1;
        step(1);
        t_reset;
        t_ctl_outputs;
        t_levels;
        t_rise_and_read;
        t_irq;
        t_coincide;
        t_loop;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule